// File: doc/BRIEF.md
# Single Pulse-Train Phase Detector

This block compares a reference edge input with a feedback edge input (the divided oscillator output) using a fast system clock. It does not report phase error as the width of an up or down pulse. It reports a count of one-clock-wide pulses on `modify_o` and gives the sign of the error on a separate level, `direction_o`. A downstream counter and DAC add or subtract one step of oscillator control current for each pulse. The direction level tells that counter which way to step.

Each edge input passes through a two-flop synchronizer and a rising-edge detector. The detected edges drive a three-state machine with the states idle, reference-leading and feedback-leading.

- The first edge of a comparison moves the machine out of idle.
- The edge from the other input returns it to idle.
- While the machine is out of idle, it produces one pulse per clock tick. It stops producing pulses once the pulse count for that comparison reaches the parameter `M`.

A programmable dead zone of 0 to 3 ticks sets how many of the first ticks of each comparison produce no pulse.

Top module: `pulse_train_pd`

## Requirements
- R1: Each input is re-timed by two flops and then edge-detected. A rising edge produces exactly one event, however many clock cycles the input stays high.
- R2: If the reference edge arrives first (the oscillator lags), `direction_o` goes to 1, meaning increase the control current. If the feedback edge arrives first (the oscillator leads), `direction_o` goes to 0, meaning decrease it. `direction_o` keeps its value until the next comparison that has a leading input.
- R3: If both edges arrive in the same tick, no pulse is produced and `direction_o` keeps its previous value.
- R4: Suppose one edge leads the other by d ticks with d greater than `dead_zone_i`. Then exactly min(d - `dead_zone_i`, M) pulses appear on `modify_o`, each high for one cycle. The lagging edge returns the detector to idle, after which no further pulses appear.
- R5: If the error d satisfies 1 <= d <= `dead_zone_i`, no pulse is produced. `direction_o` still takes the sign of the error.
- R6: If both edges are detected in the same tick while the detector is idle, it stays idle.
- R7: A single comparison never produces more than M pulses (default M = 8). This holds even if the lagging edge never arrives.
- R8: Suppose a second rising edge arrives on the leading input before the lagging edge arrives. That edge starts a new comparison, and the new comparison may produce up to M further pulses.
- R9: While the active-low asynchronous reset `rst_ni` is asserted, and right after it is released, `modify_o` and `direction_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference edge input, asynchronous |
| fb_i | input | 1 | Feedback (divided oscillator) edge input, asynchronous |
| dead_zone_i | input | DZ_W (2) | Dead zone in ticks, 0 to 3 |
| modify_o | output | 1 | One-cycle pulse per tick of phase error |
| direction_o | output | 1 | 1 = increase control current, 0 = decrease |

## Verification
The hardest state to reach is a comparison that the second edge never closes. In that case only the saturation limit stops the burst of pulses, and a later repeat of the leading edge must start a fresh burst. The bench gets there by pulsing the reference input three times, 20 ticks apart, with the feedback input held low. It expects three bursts of exactly M pulses each, and then closes the comparison with a late feedback edge. The rest of the stimulus is a sweep of every lead and lag from -12 to +12 ticks at each of the four dead-zone settings. That sweep covers the in-phase case, errors inside the dead zone and errors past saturation.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_REF_LEAD = 2'd1,
    ST_FB_LEAD  = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pd_edge_sync.sv
module pd_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], d_i};
      last_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise_o = sync_q[SYNC_N-1] & ~last_q;
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_pkg::*;
#(
  parameter int DZ_W = 2,
  parameter int M    = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_rise_i,
  input  logic            fb_rise_i,
  input  logic [DZ_W-1:0] dead_zone_i,
  output pd_state_e       state_o,
  output logic            pulse_o,
  output logic [$clog2(M+1)-1:0] pls_cnt_o
);
  localparam int AGE_W = DZ_W + 1;
  localparam int PLS_W = $clog2(M + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(2 ** DZ_W);

  pd_state_e        state_q, state_d;
  logic [AGE_W-1:0] age_q;
  logic [PLS_W-1:0] pls_q;
  logic             start;
  logic             lead;

  assign lead = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_rise_i && !fb_rise_i) begin
          state_d = ST_REF_LEAD;
          start   = 1'b1;
        end else if (fb_rise_i && !ref_rise_i) begin
          state_d = ST_FB_LEAD;
          start   = 1'b1;
        end
      end
      ST_REF_LEAD: begin
        if (fb_rise_i)       state_d = ST_IDLE;
        else if (ref_rise_i) start   = 1'b1;  // new period, restart
      end
      ST_FB_LEAD: begin
        if (ref_rise_i)      state_d = ST_IDLE;
        else if (fb_rise_i)  start   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // one unit pulse per tick once past the dead zone, capped at M
  assign pulse_o = lead && (age_q >= {1'b0, dead_zone_i}) && (pls_q < PLS_W'(M));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      age_q   <= '0;
      pls_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start) begin
        age_q <= '0;
        pls_q <= '0;
      end else begin
        if (lead && age_q != AGE_MAX) age_q <= age_q + 1'b1;
        if (pulse_o)                  pls_q <= pls_q + 1'b1;
      end
    end
  end

  assign state_o   = state_q;
  assign pls_cnt_o = pls_q;
endmodule

// File: rtl/pd_out.sv
module pd_out
  import pd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pd_state_e state_i,
  input  logic      pulse_i,
  output logic      modify_o,
  output logic      direction_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      modify_o    <= 1'b0;
      direction_o <= 1'b0;
    end else begin
      modify_o <= pulse_i;
      if (state_i == ST_REF_LEAD)     direction_o <= 1'b1;
      else if (state_i == ST_FB_LEAD) direction_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pulse_train_pd.sv
module pulse_train_pd
  import pd_pkg::*;
#(
  parameter int DZ_W   = 2,
  parameter int M      = 8,
  parameter int SYNC_N = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_i,
  input  logic            fb_i,
  input  logic [DZ_W-1:0] dead_zone_i,
  output logic            modify_o,
  output logic            direction_o
);
  localparam int NUM_IN = 2;
  localparam int PLS_W  = $clog2(M + 1);

  logic [NUM_IN-1:0] in_raw;
  logic [NUM_IN-1:0] in_rise;
  logic              ref_rise, fb_rise;
  pd_state_e         state;
  logic              pulse;
  logic [PLS_W-1:0]  pls_cnt;

  assign in_raw = {fb_i, ref_i};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    pd_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (in_raw[g]),
      .rise_o (in_rise[g])
    );
  end

  assign ref_rise = in_rise[0];
  assign fb_rise  = in_rise[1];

  pd_fsm #(.DZ_W(DZ_W), .M(M)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_rise_i  (ref_rise),
    .fb_rise_i   (fb_rise),
    .dead_zone_i (dead_zone_i),
    .state_o     (state),
    .pulse_o     (pulse),
    .pls_cnt_o   (pls_cnt)
  );

  pd_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .pulse_i     (pulse),
    .modify_o    (modify_o),
    .direction_o (direction_o)
  );
endmodule

// File: rtl/pulse_train_pd_chk.sv
module pulse_train_pd_chk
  import pd_pkg::*;
#(
  parameter int M = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input pd_state_e              state,
  input logic                   ref_rise,
  input logic                   fb_rise,
  input logic [$clog2(M+1)-1:0] pls_cnt,
  input logic                   modify_o,
  input logic                   direction_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |=> !modify_o); // R3
  AST_DIR_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_REF_LEAD |=> direction_o); // R2
  AST_DIR_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_FB_LEAD |=> !direction_o); // R2
  AST_CLOSE_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_REF_LEAD && fb_rise |=> state == ST_IDLE); // R4
  AST_CLOSE_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_FB_LEAD && ref_rise |=> state == ST_IDLE); // R4
  AST_SAME_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE && ref_rise && fb_rise |=> state == ST_IDLE); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pls_cnt == ($clog2(M+1))'(M) && $stable(pls_cnt) |=> !modify_o); // R7
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_REF_LEAD && ref_rise && !fb_rise |=> pls_cnt == '0); // R8
endmodule

bind pulse_train_pd pulse_train_pd_chk #(.M(M)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state       (state),
  .ref_rise    (ref_rise),
  .fb_rise     (fb_rise),
  .pls_cnt     (pls_cnt),
  .modify_o    (modify_o),
  .direction_o (direction_o)
);

// File: tb/pulse_train_pd_tb.sv
`timescale 1ns/1ps
module pulse_train_pd_tb;
  localparam int M = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic       fb_in = 1'b0;
  logic [1:0] dz = 2'd0;
  logic       modify, direction;

  int checks = 0;
  int errors = 0;
  int pcnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_train_pd #(.DZ_W(2), .M(M), .SYNC_N(2)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ref_i       (ref_in),
    .fb_i        (fb_in),
    .dead_zone_i (dz),
    .modify_o    (modify),
    .direction_o (direction)
  );

  always @(negedge clk) if (modify) pcnt++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  // lead d>0: reference first by d ticks; d<0: feedback first
  task automatic trial(int d, int dzv);
    int ad, exp_p, dir_before;
    dz = dzv[1:0];
    ticks(6);
    pcnt = 0;
    dir_before = direction;
    ad = (d < 0) ? -d : d;
    if (d >= 0) begin
      ref_in = 1'b1; ticks(ad); fb_in = 1'b1;
    end else begin
      fb_in = 1'b1; ticks(ad); ref_in = 1'b1;
    end
    ticks(4);
    ref_in = 1'b0; fb_in = 1'b0;
    ticks(20);
    exp_p = (ad > dzv) ? ((ad - dzv) > M ? M : (ad - dzv)) : 0;
    if (d == 0)              check("R3 in-phase pulses", pcnt, 0);
    else if (ad <= dzv)      check("R5 dead-zone pulses", pcnt, 0);
    else if (ad - dzv > M)   check("R7 saturated pulses", pcnt, exp_p);
    else                     check("R4 pulse count", pcnt, exp_p);
    if (d > 0)      check("R2 lag direction", int'(direction), 1);
    else if (d < 0) check("R2 lead direction", int'(direction), 0);
    else            check("R3 in-phase direction held", int'(direction), dir_before);
  endtask

  initial begin
    ticks(2);
    check("R9 modify in reset", int'(modify), 0);
    check("R9 direction in reset", int'(direction), 0);
    rst_n = 1'b1;
    ticks(3);
    check("R9 modify after reset", int'(modify), 0);
    check("R9 direction after reset", int'(direction), 0);

    // R6 simultaneous edges from idle right after reset
    trial(0, 0);

    for (int z = 0; z < 4; z++)
      for (int d = -12; d <= 12; d++)
        trial(d, z);

    // R1 long-held input: one event only
    dz = 2'd0;
    ticks(6);
    pcnt = 0;
    ref_in = 1'b1; ticks(3); fb_in = 1'b1;
    ticks(40);
    ref_in = 1'b0; fb_in = 1'b0;
    ticks(20);
    check("R1 held-high inputs single event", pcnt, 3);

    // R8 / R7 missing feedback edge, three reference periods
    ticks(6);
    pcnt = 0;
    for (int p = 0; p < 3; p++) begin
      ref_in = 1'b1; ticks(4); ref_in = 1'b0; ticks(16);
    end
    ticks(20);
    check("R8 restart per period (R7 cap each)", pcnt, 3 * M);
    check("R2 direction during missing edge", int'(direction), 1);
    fb_in = 1'b1; ticks(4); fb_in = 1'b0; ticks(20);
    check("R7 no pulse on late close", pcnt, 3 * M);
    trial(5, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule